// File: doc/BRIEF.md
# Chained-Descriptor Copy Engine

This block is a single-channel copy engine. It walks a chain of descriptors held in memory and gathers a series of source buffers, one after another, into a single contiguous destination region. Software writes the chain into memory, gives the engine the address of the first descriptor, and pulses a start input. From then on the engine runs the whole chain by itself. It uses one memory master port for descriptor reads, data reads, data writes and status writes.

A descriptor is five consecutive 32-bit words: source address, destination address, control A, control B and next-descriptor pointer, at byte offsets 0, 4, 8, 12 and 16. In control A, bits [15:0] hold the buffer length in words and bit 31 is the completion flag. Before moving the data of a buffer, the engine clears the flag in memory. When the buffer is finished, it writes back control A with the flag set. This lets software learn that a buffer is complete by polling the copy in memory. The engine raises a one-cycle interrupt for every buffer and moves straight on to the next descriptor. Only the first descriptor's destination field is used. Each later buffer lands directly after the previous one. A next pointer of zero marks the final buffer.

Top module: `lli_dma_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_req_o, busy_o, buf_irq_o and chain_done_o are all low.
- R2: A start pulse received while idle makes the engine read five words, in ascending order of byte address, starting at first_desc_i and stepping by 4. The cycle after the start, the first request is a read of first_desc_i.
- R3: Before any data write of a buffer, the engine writes that descriptor's control A word (byte offset 8) with bit 31 cleared and every other bit as fetched.
- R4: A buffer of length N (control A bits [15:0]) is copied as N words. The words are read from ascending source addresses, and each read is followed by the write of that word to the running destination address.
- R5: The destination word of the first descriptor sets the destination address. The destination words of later descriptors are ignored, so successive buffers are packed one after another.
- R6: At the end of a buffer, the engine writes control A back to byte offset 8 of that descriptor with bit 31 set, bits [15:0] equal to the number of words moved, and the other bits as fetched. No other descriptor word is written. The interrupt follows in the cycle after this write is accepted.
- R7: buf_irq_o is a one-cycle pulse, issued exactly once per buffer. The engine continues with the next descriptor without any acknowledgement.
- R8: When the finished buffer's next pointer is zero, the engine goes idle and issues no further request. chain_done_o goes high and stays high until the next accepted start.
- R9: A buffer of length zero causes no data access, but it still gets the flag clear, the writeback and the interrupt.
- R10: At most one memory access is in flight. No request is made while read data is outstanding, and a request keeps its address, direction and write data unchanged until mem_gnt_i.
- R11: A start pulse while busy_o is high is ignored: the running chain is neither restarted nor redirected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| first_desc_i | input | ADDR_W | Byte address of the first descriptor |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write when high |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | DATA_W | Write data |
| mem_gnt_i | input | 1 | Memory accepts the request in this cycle |
| mem_rvalid_i | input | 1 | Read data is valid |
| mem_rdata_i | input | DATA_W | Read data |
| buf_irq_o | output | 1 | One-cycle pulse per completed buffer |
| chain_done_o | output | 1 | Chain finished; cleared by the next start |
| busy_o | output | 1 | Engine is walking a chain |

## Verification
The bench sweeps chains of one to three descriptors, with buffer lengths from zero to four, across three memory timing patterns. The patterns are immediate grant with next-cycle data, grant every other cycle with two-cycle data, and pseudo-random grant with three-cycle data. Varying the lengths separates a correct length count from off-by-one errors, and exposes zero-length buffers that would wrongly move data. Multi-buffer chains whose later destination fields point at a decoy area show whether the destination is reloaded when it must not be. The slow timing patterns separate a correct one-at-a-time handshake from one that drops or repeats an access. Flipping the initial completion flag between runs shows whether the flag is really cleared and then set again, rather than left as it was found.

// File: rtl/lli_dma_pkg.sv
package lli_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CLEAR,
      ST_RD,
      ST_WR,
      ST_WBACK,
      ST_NEXT
   } dma_state_e;

   localparam int unsigned DESC_WORDS = 5;
   localparam int unsigned W_SRC      = 0;
   localparam int unsigned W_DST      = 1;
   localparam int unsigned W_CTLA     = 2;
   localparam int unsigned W_CTLB     = 3;
   localparam int unsigned W_NEXT     = 4;
   localparam int unsigned IDX_W      = 3;

endpackage

// File: rtl/lli_mem_if.sv
module lli_mem_if #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_we,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              op_done,
   output logic [DATA_W-1:0] op_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   logic pend_q;

   assign mem_req   = cmd_valid & ~pend_q;
   assign mem_we    = cmd_we;
   assign mem_addr  = cmd_addr;
   assign mem_wdata = cmd_wdata;
   assign op_rdata  = mem_rdata;
   assign op_done   = (mem_req & mem_gnt & cmd_we) | (pend_q & mem_rvalid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (mem_req && mem_gnt && !cmd_we) begin
         pend_q <= 1'b1;
      end else if (pend_q && mem_rvalid) begin
         pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/lli_desc_regs.sv
module lli_desc_regs
   import lli_dma_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_dst_en,
   input  logic              src_step,
   input  logic              dst_step,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [DATA_W-1:0] ctla_q,
   output logic [ADDR_W-1:0] next_q
);

   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

   logic hit_src, hit_dst, hit_ctla, hit_next;

   assign hit_src  = ld_en && (ld_idx == IDX_W'(W_SRC));
   assign hit_dst  = ld_en && ld_dst_en && (ld_idx == IDX_W'(W_DST));
   assign hit_ctla = ld_en && (ld_idx == IDX_W'(W_CTLA));
   assign hit_next = ld_en && (ld_idx == IDX_W'(W_NEXT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
      end else if (hit_src) begin
         src_q <= ld_data[ADDR_W-1:0];
      end else if (src_step) begin
         src_q <= src_q + STEP_A;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_q <= '0;
      end else if (hit_dst) begin
         dst_q <= ld_data[ADDR_W-1:0];
      end else if (dst_step) begin
         dst_q <= dst_q + STEP_A;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctla_q <= '0;
         next_q <= '0;
      end else begin
         if (hit_ctla) ctla_q <= ld_data;
         if (hit_next) next_q <= ld_data[ADDR_W-1:0];
      end
   end

endmodule

// File: rtl/lli_dma_fsm.sv
module lli_dma_fsm
   import lli_dma_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SIZE_W   = 16,
   parameter int unsigned DONE_BIT = 31,
   parameter int unsigned STEP     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] first_desc_i,
   output logic              cmd_valid,
   output logic              cmd_we,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic              op_done,
   input  logic [DATA_W-1:0] op_rdata,
   output logic              ld_en,
   output logic [IDX_W-1:0]  ld_idx,
   output logic              ld_dst_en,
   output logic              src_step,
   output logic              dst_step,
   input  logic [ADDR_W-1:0] src_q,
   input  logic [ADDR_W-1:0] dst_q,
   input  logic [DATA_W-1:0] ctla_q,
   input  logic [ADDR_W-1:0] next_q,
   output logic              buf_irq,
   output logic              chain_done,
   output logic              busy
);

   localparam logic [ADDR_W-1:0] STEP_A   = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] CTLA_OFS = ADDR_W'(W_CTLA * STEP);
   localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(DESC_WORDS - 1);

   dma_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              first_q;
   logic [SIZE_W-1:0] cnt_q;
   logic [DATA_W-1:0] hold_q;
   logic              done_q;

   logic [SIZE_W-1:0] size_w;
   logic              last_word;
   logic [DATA_W-1:0] clr_word;
   logic [DATA_W-1:0] wb_word;

   assign size_w    = ctla_q[SIZE_W-1:0];
   assign last_word = (cnt_q + 1'b1) == size_w;

   always_comb begin
      clr_word           = ctla_q;
      clr_word[DONE_BIT] = 1'b0;
      wb_word            = ctla_q;
      wb_word[DONE_BIT]  = 1'b1;
      wb_word[SIZE_W-1:0] = cnt_q;
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_we    = 1'b0;
      cmd_addr  = base_q;
      cmd_wdata = '0;
      unique case (state_q)
         ST_FETCH: begin
            cmd_valid = 1'b1;
            cmd_addr  = base_q + ADDR_W'(idx_q) * STEP_A;
         end
         ST_CLEAR: begin
            cmd_valid = 1'b1;
            cmd_we    = 1'b1;
            cmd_addr  = base_q + CTLA_OFS;
            cmd_wdata = clr_word;
         end
         ST_RD: begin
            cmd_valid = 1'b1;
            cmd_addr  = src_q;
         end
         ST_WR: begin
            cmd_valid = 1'b1;
            cmd_we    = 1'b1;
            cmd_addr  = dst_q;
            cmd_wdata = hold_q;
         end
         ST_WBACK: begin
            cmd_valid = 1'b1;
            cmd_we    = 1'b1;
            cmd_addr  = base_q + CTLA_OFS;
            cmd_wdata = wb_word;
         end
         default: ;
      endcase
   end

   assign ld_en      = (state_q == ST_FETCH) && op_done;
   assign ld_idx     = idx_q;
   assign ld_dst_en  = first_q;
   assign src_step   = (state_q == ST_RD) && op_done;
   assign dst_step   = (state_q == ST_WR) && op_done;
   assign buf_irq    = (state_q == ST_NEXT);
   assign busy       = (state_q != ST_IDLE);
   assign chain_done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
         first_q <= 1'b0;
         cnt_q   <= '0;
         hold_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  base_q  <= first_desc_i;
                  idx_q   <= '0;
                  first_q <= 1'b1;
                  done_q  <= 1'b0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (op_done) begin
                  if (idx_q == IDX_LAST) begin
                     idx_q   <= '0;
                     state_q <= ST_CLEAR;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_CLEAR: begin
               if (op_done) begin
                  first_q <= 1'b0;
                  cnt_q   <= '0;
                  state_q <= (size_w == '0) ? ST_WBACK : ST_RD;
               end
            end
            ST_RD: begin
               if (op_done) begin
                  hold_q  <= op_rdata;
                  state_q <= ST_WR;
               end
            end
            ST_WR: begin
               if (op_done) begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= last_word ? ST_WBACK : ST_RD;
               end
            end
            ST_WBACK: begin
               if (op_done) state_q <= ST_NEXT;
            end
            ST_NEXT: begin
               if (next_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  base_q  <= next_q;
                  state_q <= ST_FETCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lli_dma_engine.sv
module lli_dma_engine
   import lli_dma_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SIZE_W    = 16,
   parameter int unsigned DONE_BIT  = 31,
   parameter bit          BYTE_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] first_desc_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              buf_irq_o,
   output logic              chain_done_o,
   output logic              busy_o
);

   localparam int unsigned STEP = BYTE_ADDR ? (DATA_W / 8) : 1;

   if (ADDR_W > DATA_W) begin : g_chk_addr
      $error("address width must fit in one descriptor word");
   end
   if (SIZE_W >= DONE_BIT + 1 || DONE_BIT >= DATA_W) begin : g_chk_fields
      $error("length field and completion flag must be disjoint and inside a word");
   end
   if (BYTE_ADDR && (DATA_W % 8 != 0)) begin : g_chk_bytes
      $error("byte addressing needs a whole number of bytes per word");
   end

   logic              cmd_valid, cmd_we, op_done;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata, op_rdata;
   logic              ld_en, ld_dst_en, src_step, dst_step;
   logic [IDX_W-1:0]  ld_idx;
   logic [ADDR_W-1:0] src_q, dst_q, next_q;
   logic [DATA_W-1:0] ctla_q;

   lli_mem_if #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_mem_if (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_we     (cmd_we),
      .cmd_addr   (cmd_addr),
      .cmd_wdata  (cmd_wdata),
      .op_done    (op_done),
      .op_rdata   (op_rdata),
      .mem_req    (mem_req_o),
      .mem_we     (mem_we_o),
      .mem_addr   (mem_addr_o),
      .mem_wdata  (mem_wdata_o),
      .mem_gnt    (mem_gnt_i),
      .mem_rvalid (mem_rvalid_i),
      .mem_rdata  (mem_rdata_i)
   );

   lli_desc_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STEP   (STEP)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .ld_idx    (ld_idx),
      .ld_data   (op_rdata),
      .ld_dst_en (ld_dst_en),
      .src_step  (src_step),
      .dst_step  (dst_step),
      .src_q     (src_q),
      .dst_q     (dst_q),
      .ctla_q    (ctla_q),
      .next_q    (next_q)
   );

   lli_dma_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SIZE_W   (SIZE_W),
      .DONE_BIT (DONE_BIT),
      .STEP     (STEP)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .first_desc_i (first_desc_i),
      .cmd_valid    (cmd_valid),
      .cmd_we       (cmd_we),
      .cmd_addr     (cmd_addr),
      .cmd_wdata    (cmd_wdata),
      .op_done      (op_done),
      .op_rdata     (op_rdata),
      .ld_en        (ld_en),
      .ld_idx       (ld_idx),
      .ld_dst_en    (ld_dst_en),
      .src_step     (src_step),
      .dst_step     (dst_step),
      .src_q        (src_q),
      .dst_q        (dst_q),
      .ctla_q       (ctla_q),
      .next_q       (next_q),
      .buf_irq      (buf_irq_o),
      .chain_done   (chain_done_o),
      .busy         (busy_o)
   );

endmodule

// File: rtl/lli_dma_checker.sv
module lli_dma_checker #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DONE_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] first_desc_i,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_gnt_i,
   input logic              mem_rvalid_i,
   input logic              buf_irq_o,
   input logic              chain_done_o,
   input logic              busy_o
);

   logic rd_out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_out_q <= 1'b0;
      end else if (mem_req_o && mem_gnt_i && !mem_we_o) begin
         rd_out_q <= 1'b1;
      end else if (mem_rvalid_i) begin
         rd_out_q <= 1'b0;
      end
   end

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o));

   p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_out_q |-> !mem_req_o);

   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq_o |=> !buf_irq_o);

   p_irq_after_wback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq_o |-> $past(mem_req_o && mem_gnt_i && mem_we_o && mem_wdata_o[DONE_BIT]));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done_o |-> !busy_o);

   p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mem_req_o && !mem_we_o && (mem_addr_o == $past(first_desc_i)));

   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !buf_irq_o |=> busy_o);

endmodule

bind lli_dma_engine lli_dma_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .DONE_BIT (DONE_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .first_desc_i (first_desc_i),
   .mem_req_o    (mem_req_o),
   .mem_we_o     (mem_we_o),
   .mem_addr_o   (mem_addr_o),
   .mem_wdata_o  (mem_wdata_o),
   .mem_gnt_i    (mem_gnt_i),
   .mem_rvalid_i (mem_rvalid_i),
   .buf_irq_o    (buf_irq_o),
   .chain_done_o (chain_done_o),
   .busy_o       (busy_o)
);

// File: tb/test_lli_dma_engine.sv
`timescale 1ns/1ps
module test_lli_dma_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] first_desc_i = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        buf_irq, chain_done, busy;

   always #2.5 clk = ~clk;

   lli_dma_engine i_lli_dma_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .first_desc_i (first_desc_i),
      .mem_req_o    (mem_req),
      .mem_we_o     (mem_we),
      .mem_addr_o   (mem_addr),
      .mem_wdata_o  (mem_wdata),
      .mem_gnt_i    (mem_gnt),
      .mem_rvalid_i (mem_rvalid),
      .mem_rdata_i  (mem_rdata),
      .buf_irq_o    (buf_irq),
      .chain_done_o (chain_done),
      .busy_o       (busy)
   );

   int vectors = 0, miscompares = 0;
   logic [31:0] mem [256];
   int mode = 0;
   int desc_rd, seq_err, clr_cnt, wb_cnt, data_wr, order_err, irq_cnt, outst_err;
   bit cleared, rd_pend, ok, tog;
   int lat;
   logic [31:0] rd_val, exp_a;
   logic [7:0] lfsr = 8'h5b;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: decides grant and read latency at the falling edge
   initial forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_gnt    = 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tog  = !tog;
      if (buf_irq) irq_cnt++;
      if (rd_pend) begin
         if (mem_req) outst_err++;
         if (lat == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd_val;
            rd_pend    = 1'b0;
         end else begin
            lat--;
         end
      end else if (mem_req) begin
         ok = (mode == 0) || (mode == 1 && tog) || (mode == 2 && lfsr[0]);
         if (ok) begin
            mem_gnt = 1'b1;
            if (mem_we) begin
               mem[mem_addr[9:2]] = mem_wdata;
               if (mem_addr < 32'h100 && mem_addr[4:0] == 5'h08) begin
                  if (mem_wdata[31]) begin wb_cnt++; cleared = 1'b0; end
                  else begin clr_cnt++; cleared = 1'b1; end
               end else if (mem_addr >= 32'h300) begin
                  data_wr++;
                  if (!cleared) order_err++;
               end
            end else begin
               rd_pend = 1'b1;
               lat     = mode;
               rd_val  = mem[mem_addr[9:2]];
               if (mem_addr < 32'h100) begin
                  exp_a = 32'h40 + 32'(desc_rd / 5) * 32'h20 + 32'(desc_rd % 5) * 4;
                  if (mem_addr !== exp_a) seq_err++;
                  desc_rd++;
               end
            end
         end
      end
   end

   function automatic logic [31:0] pat(int tag, int i, int k);
      return 32'h0C00_0000 ^ (32'(tag) << 16) ^ (32'(i) << 8) ^ 32'(k)
             ^ ((k % 2 == 1) ? 32'h8000_0000 : 32'h0);
   endfunction

   task automatic run(int nb, int base, int md, int tag);
      int sz[3];
      logic [31:0] ctla[3];
      int total = 0;
      int j = 0;
      int quiet = 0;
      mode = md;
      for (int w = 0; w < 256; w++) mem[w] = '0;
      for (int i = 0; i < nb; i++) begin
         sz[i]   = (base + i * 3) % 5;
         total  += sz[i];
         ctla[i] = 32'(sz[i]) | 32'h0012_0000 | (((tag + i) % 2 == 1) ? 32'h8000_0000 : 32'h0);
         mem[16 + 8*i]     = 32'h200 + 32'(i) * 32'h40;
         mem[16 + 8*i + 1] = (i == 0) ? 32'h300 : 32'h380;
         mem[16 + 8*i + 2] = ctla[i];
         mem[16 + 8*i + 3] = 32'h5A5A_0000 + 32'(i);
         mem[16 + 8*i + 4] = (i == nb - 1) ? 32'h0 : 32'h40 + 32'(i + 1) * 32'h20;
         for (int k = 0; k < 16; k++) mem[128 + 16*i + k] = pat(tag, i, k);
      end
      for (int k = 0; k < 16; k++) begin
         mem[192 + k] = 32'hDEAD_0000 + 32'(k);
         mem[224 + k] = 32'hBEEF_0000 + 32'(k);
      end
      desc_rd = 0; seq_err = 0; clr_cnt = 0; wb_cnt = 0; data_wr = 0;
      order_err = 0; irq_cnt = 0; outst_err = 0; cleared = 1'b0;
      @(negedge clk); start_i = 1'b1; first_desc_i = 32'h40;
      @(negedge clk); start_i = 1'b0;
      check("R8 chain_done cleared by start", 32'(chain_done), 0);
      check("R2 busy after start", 32'(busy), 1);
      @(negedge clk); start_i = 1'b1; first_desc_i = 32'hE0;   // R11: must be ignored
      @(negedge clk); start_i = 1'b0;
      for (int c = 0; c < 4000 && !chain_done; c++) @(negedge clk);
      check("R8 chain_done", 32'(chain_done), 1);
      check("R8 idle at end", 32'(busy), 0);
      check("R7 irq per buffer", 32'(irq_cnt), 32'(nb));
      check("R2 R11 descriptor read order", 32'(seq_err), 0);
      check("R8 R11 descriptor read count", 32'(desc_rd), 32'(5 * nb));
      check("R3 flag clears", 32'(clr_cnt), 32'(nb));
      check("R3 clear before data", 32'(order_err), 0);
      check("R6 writebacks", 32'(wb_cnt), 32'(nb));
      check("R9 R4 data write count", 32'(data_wr), 32'(total));
      check("R10 no request while read pending", 32'(outst_err), 0);
      for (int i = 0; i < nb; i++) begin
         check("R6 writeback word", mem[16 + 8*i + 2], ctla[i] | 32'h8000_0000);
         check("R6 source word untouched", mem[16 + 8*i], 32'h200 + 32'(i) * 32'h40);
         check("R6 dest word untouched", mem[16 + 8*i + 1], (i == 0) ? 32'h300 : 32'h380);
         check("R6 ctlB untouched", mem[16 + 8*i + 3], 32'h5A5A_0000 + 32'(i));
         for (int k = 0; k < sz[i]; k++) begin
            check("R4 R5 contiguous data", mem[192 + j], pat(tag, i, k));
            j++;
         end
      end
      for (int k = total; k < 16; k++) check("R9 R4 no extra write", mem[192 + k], 32'hDEAD_0000 + 32'(k));
      for (int k = 0; k < 16; k++) check("R5 decoy area untouched", mem[224 + k], 32'hBEEF_0000 + 32'(k));
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         if (mem_req || busy || !chain_done) quiet++;
      end
      check("R8 quiet after chain", 32'(quiet), 0);
   endtask

   initial begin
      int tag = 0;
      repeat (3) @(negedge clk);
      check("R1 req in reset", 32'(mem_req), 0);
      check("R1 busy in reset", 32'(busy), 0);
      check("R1 irq in reset", 32'(buf_irq), 0);
      check("R1 done in reset", 32'(chain_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 req after reset", 32'(mem_req), 0);
      check("R1 busy after reset", 32'(busy), 0);
      for (int nb = 1; nb <= 3; nb++)
         for (int b = 0; b < 5; b++)
            for (int md = 0; md < 3; md++) begin
               run(nb, b, md, tag);
               tag++;
            end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule